// File: doc/BRIEF.md
# Wander-Tolerant Elastic Buffer with Slip Detector

This block carries B1, B2 and D channel bits between a line interface and a system bus. The two sides run at the same nominal bit rate, but their phase relation is arbitrary and drifts. There are two independent lanes. Lane 0 carries line-receive traffic to the bus, and lane 1 carries bus traffic to the line transmitter. Each lane is a small circular bit store. One side writes it under its own bit-tick enable and the other side reads it under its own. Both enables are qualifiers on one fast core clock, and the phase between them is arbitrary. The store depth is a whole number of frames. The default is three frames of 18 bits, which gives room for three B1 octets, three B2 octets and six D bits.

After reset every lane starts centred: occupancy equals half the depth. On each read-side frame strobe the lane measures how far the occupancy has moved from that centre. A deviation beyond the slip limit raises a sticky slip flag and re-centres the read pointer, and some data may be lost at that point. When the warning enable is set, a deviation beyond half the slip limit raises a sticky warning instead. A per-lane acknowledge clears either flag. The block also produces a line transmit frame mark that lags the line receive frame start by a fixed number of line bit ticks, two by default.

Each lane is controlled by a four-state machine:
- FILL: output is idle ones. It moves to LOCKED when a full write frame, begun with a write frame strobe, has been stored.
- LOCKED: no flag is set. A measurement beyond the slip limit moves it to SLIPPED. A measurement beyond the warning limit with the warning enabled moves it to WARNED.
- WARNED: the warning is shown. A measurement beyond the slip limit moves it to SLIPPED. A measurement beyond the warning limit keeps it in WARNED. Otherwise an acknowledge returns it to LOCKED.
- SLIPPED: the slip is shown. A measurement beyond the slip limit re-centres the lane again and it stays in SLIPPED. Otherwise an acknowledge returns it to LOCKED.

Top module: `elastic_slip_buffer`

## Requirements
- R1: After reset, every lane has slip and warn low and rd_bit high, and its occupancy is half the depth (DEPTH = FRAME_BITS*FRAMES).
- R2: Until a complete write frame has been stored, every read returns 1. A complete frame is FRAME_BITS written bits, the first carrying wr_sof.
- R3: Once primed and while no slip occurs, reads return the written bits in write order. Reads and writes may occur in the same cycle, and the read value is registered on rd_bit.
- R4: Deviation is |occupancy − DEPTH/2|. It is evaluated only in a cycle with rd_sof, so without rd_sof no flag rises, whatever the deviation.
- R5: If deviation > SLIP_DEV in an rd_sof cycle, slip is high from the next cycle.
- R6: On a slip, the read pointer is set to the write pointer plus DEPTH/2 modulo DEPTH. After DEPTH/2 lockstep write/read ticks, reads return the bits written from the slip onward, in order.
- R7: Slip stays high until slip_ack is given in a cycle without a new slip measurement, and it is low in the cycle after that acknowledge.
- R8: With warn_en = 1, a deviation in (SLIP_DEV/2, SLIP_DEV] at rd_sof raises warn from the next cycle. With warn_en = 0, warn never rises.
- R9: Warn is sticky until slip_ack. Slip and warn are never high together, and a slip measurement in WARNED drops warn and raises slip.
- R10: When rd_sof and slip_ack coincide, the measurement decides the next flag state.
- R11: line_tx_sof is high in the lane 0 write-tick cycle that comes TX_DELAY lane 0 write ticks after the tick carrying wr_sof[0], and only in write-tick cycles.
- R12: The lanes are independent: activity on one lane never raises the other lane's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warn_en | input | 1 | Enables the half-limit warning |
| wr_en | input | 2 | Per-lane write bit tick |
| wr_sof | input | 2 | Per-lane marker on the first bit of a write frame |
| wr_bit | input | 2 | Per-lane write data bit |
| rd_en | input | 2 | Per-lane read bit tick |
| rd_sof | input | 2 | Per-lane read frame strobe, the measurement instant |
| slip_ack | input | 2 | Per-lane flag acknowledge |
| rd_bit | output | 2 | Per-lane registered read data bit |
| slip | output | 2 | Per-lane sticky slip flag |
| warn | output | 2 | Per-lane sticky warning flag |
| line_tx_sof | output | 1 | Line transmit frame mark, delayed from line receive frame start |

## Verification
The bench builds the block with FRAME_BITS = 4, FRAMES = 2 and SLIP_DEV = 2. That gives an 8-bit store centred at 4, a slip limit of 2 and a warning limit of 1. With these values every possible deviation from −4 to +4 can be reached in a few ticks. The bench sweeps all of them on both lanes with the warning enable both off and on, so every state and transition of the lane machine is visited, including repeated slips, an acknowledge that coincides with a measurement, and an escalation from warning to slip.

// File: rtl/eb_pkg.sv
package eb_pkg;
    typedef enum logic [1:0] {
        ST_FILL,
        ST_LOCKED,
        ST_WARNED,
        ST_SLIPPED
    } eb_state_e;
endpackage

// File: rtl/eb_store.sv
module eb_store #(
    parameter int DEPTH = 54,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bit,
    input  logic          rd_en,
    input  logic          primed,
    input  logic          recenter,
    output logic          rd_bit,
    output logic [PW-1:0] fill
);
    localparam int HALF = DEPTH / 2;

    logic [DEPTH-1:0] mem;
    logic [PW-1:0]    wp, rp;
    logic [PW:0]      centre_sum, occ_wide;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        centre_sum = {1'b0, wp} + (PW+1)'(HALF);
        if (centre_sum >= (PW+1)'(DEPTH))
            centre_sum = centre_sum - (PW+1)'(DEPTH);
        if (wp >= rp)
            occ_wide = {1'b0, wp} - {1'b0, rp};
        else
            occ_wide = {1'b0, wp} + (PW+1)'(DEPTH) - {1'b0, rp};
        fill = occ_wide[PW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem    <= '1;
            wp     <= '0;
            rp     <= PW'(HALF);
            rd_bit <= 1'b1;
        end else begin
            if (wr_en) begin
                mem[wp] <= wr_bit;
                wp      <= step(wp);
            end
            if (rd_en)
                rd_bit <= primed ? mem[rp] : 1'b1;
            if (recenter)
                rp <= centre_sum[PW-1:0];
            else if (rd_en)
                rp <= step(rp);
        end
    end
endmodule

// File: rtl/eb_detect.sv
module eb_detect
    import eb_pkg::*;
#(
    parameter int FRAME_BITS = 18,
    parameter int DEPTH      = 54,
    parameter int SLIP_DEV   = 10,
    parameter int WARN_DEV   = 5,
    parameter int PW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sof,
    input  logic          rd_sof,
    input  logic          warn_en,
    input  logic          ack,
    input  logic [PW-1:0] fill,
    output logic          primed,
    output logic          recenter,
    output logic          slip,
    output logic          warn
);
    localparam int HALF = DEPTH / 2;
    localparam int CW   = $clog2(FRAME_BITS + 1);

    eb_state_e     st, st_next;
    logic [CW-1:0] cnt;
    logic [PW-1:0] dev;
    logic          over_slip, over_warn, frame_done, meas_slip, meas_warn;

    always_comb begin
        dev        = (fill >= PW'(HALF)) ? fill - PW'(HALF) : PW'(HALF) - fill;
        over_slip  = int'(dev) > SLIP_DEV;
        over_warn  = warn_en && (int'(dev) > WARN_DEV);
        meas_slip  = rd_sof && over_slip;
        meas_warn  = rd_sof && over_warn;
        if (wr_sof)
            frame_done = wr_en && (FRAME_BITS == 1);
        else
            frame_done = wr_en && (cnt != '0) && (cnt == CW'(FRAME_BITS - 1));
    end

    // write frame bit counter: zero means no frame has started yet
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr_en && wr_sof)
            cnt <= CW'(1);
        else if (wr_en && (cnt != '0) && (cnt < CW'(FRAME_BITS)))
            cnt <= cnt + 1'b1;
    end

    always_comb begin
        st_next = st;
        unique case (st)
            ST_FILL:    if (frame_done) st_next = ST_LOCKED;
            ST_LOCKED: begin
                if (meas_slip)      st_next = ST_SLIPPED;
                else if (meas_warn) st_next = ST_WARNED;
            end
            ST_WARNED: begin
                if (meas_slip)      st_next = ST_SLIPPED;
                else if (meas_warn) st_next = ST_WARNED;
                else if (ack)       st_next = ST_LOCKED;
            end
            ST_SLIPPED: begin
                if (meas_slip)      st_next = ST_SLIPPED;
                else if (ack)       st_next = ST_LOCKED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_FILL;
        else        st <= st_next;
    end

    always_comb begin
        primed   = (st != ST_FILL);
        recenter = (st != ST_FILL) && meas_slip;
        slip     = (st == ST_SLIPPED);
        warn     = (st == ST_WARNED);
    end
endmodule

// File: rtl/eb_lane.sv
module eb_lane #(
    parameter int FRAME_BITS = 18,
    parameter int DEPTH      = 54,
    parameter int SLIP_DEV   = 10,
    parameter int WARN_DEV   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic warn_en,
    input  logic wr_en,
    input  logic wr_sof,
    input  logic wr_bit,
    input  logic rd_en,
    input  logic rd_sof,
    input  logic ack,
    output logic rd_bit,
    output logic slip,
    output logic warn
);
    localparam int PW = $clog2(DEPTH);

    logic [PW-1:0] fill;
    logic          primed, recenter;

    eb_store #(.DEPTH(DEPTH), .PW(PW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit),
        .rd_en(rd_en), .primed(primed), .recenter(recenter),
        .rd_bit(rd_bit), .fill(fill)
    );

    eb_detect #(
        .FRAME_BITS(FRAME_BITS), .DEPTH(DEPTH), .SLIP_DEV(SLIP_DEV),
        .WARN_DEV(WARN_DEV), .PW(PW)
    ) u_detect (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sof(wr_sof),
        .rd_sof(rd_sof), .warn_en(warn_en), .ack(ack), .fill(fill),
        .primed(primed), .recenter(recenter), .slip(slip), .warn(warn)
    );
endmodule

// File: rtl/elastic_slip_buffer.sv
module elastic_slip_buffer #(
    parameter int FRAME_BITS = 18,
    parameter int FRAMES     = 3,
    parameter int SLIP_DEV   = 10,
    parameter int TX_DELAY   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       warn_en,
    input  logic [1:0] wr_en,
    input  logic [1:0] wr_sof,
    input  logic [1:0] wr_bit,
    input  logic [1:0] rd_en,
    input  logic [1:0] rd_sof,
    input  logic [1:0] slip_ack,
    output logic [1:0] rd_bit,
    output logic [1:0] slip,
    output logic [1:0] warn,
    output logic       line_tx_sof
);
    localparam int LANES    = 2;
    localparam int DEPTH    = FRAME_BITS * FRAMES;
    localparam int WARN_DEV = SLIP_DEV / 2;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        eb_lane #(
            .FRAME_BITS(FRAME_BITS), .DEPTH(DEPTH),
            .SLIP_DEV(SLIP_DEV), .WARN_DEV(WARN_DEV)
        ) u_lane (
            .clk(clk), .rst_n(rst_n), .warn_en(warn_en),
            .wr_en(wr_en[g]), .wr_sof(wr_sof[g]), .wr_bit(wr_bit[g]),
            .rd_en(rd_en[g]), .rd_sof(rd_sof[g]), .ack(slip_ack[g]),
            .rd_bit(rd_bit[g]), .slip(slip[g]), .warn(warn[g])
        );
    end

    // transmit frame mark trails line receive frame start by TX_DELAY line ticks
    logic [TX_DELAY-1:0] sof_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sof_sh <= '0;
        else if (wr_en[0]) begin
            sof_sh[0] <= wr_sof[0];
            for (int k = 1; k < TX_DELAY; k++)
                sof_sh[k] <= sof_sh[k-1];
        end
    end

    assign line_tx_sof = wr_en[0] & sof_sh[TX_DELAY-1];
endmodule

// File: rtl/eb_checker.sv
module eb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       warn_en,
    input logic [1:0] wr_en,
    input logic [1:0] rd_sof,
    input logic [1:0] slip_ack,
    input logic [1:0] slip,
    input logic [1:0] warn,
    input logic       line_tx_sof
);
    for (genvar i = 0; i < 2; i++) begin : g_chk
        p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(slip[i] && warn[i]));
        p_slip_from_measure_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(slip[i]) |-> $past(rd_sof[i]));
        p_warn_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(warn[i]) |-> ($past(warn_en) && $past(rd_sof[i])));
        p_slip_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (slip[i] && !slip_ack[i]) |=> slip[i]);
        p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (slip[i] && slip_ack[i] && !rd_sof[i]) |=> !slip[i]);
        p_warn_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (warn[i] && !slip_ack[i] && !rd_sof[i]) |=> warn[i]);
    end

    p_tx_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        line_tx_sof |-> wr_en[0]);
endmodule

bind elastic_slip_buffer eb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .warn_en(warn_en), .wr_en(wr_en),
    .rd_sof(rd_sof), .slip_ack(slip_ack), .slip(slip), .warn(warn),
    .line_tx_sof(line_tx_sof)
);

// File: tb/elastic_slip_buffer_test.sv
module elastic_slip_buffer_test;
    localparam int CLK_PERIOD = 10;
    localparam int FB   = 4;
    localparam int FR   = 2;
    localparam int SD   = 2;
    localparam int HALF = FB * FR / 2;
    localparam int WD   = SD / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       warn_en = 1'b0;
    logic [1:0] wr_en = '0, wr_sof = '0, wr_bit = '0;
    logic [1:0] rd_en = '0, rd_sof = '0, slip_ack = '0;
    wire  [1:0] rd_bit, slip, warn;
    wire        line_tx_sof;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;
    bit   txs;
    logic [7:0] seed = 8'h5A;
    bit   q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    elastic_slip_buffer #(.FRAME_BITS(FB), .FRAMES(FR), .SLIP_DEV(SD), .TX_DELAY(2)) uut (
        .clk(clk), .rst_n(rst_n), .warn_en(warn_en),
        .wr_en(wr_en), .wr_sof(wr_sof), .wr_bit(wr_bit),
        .rd_en(rd_en), .rd_sof(rd_sof), .slip_ack(slip_ack),
        .rd_bit(rd_bit), .slip(slip), .warn(warn), .line_tx_sof(line_tx_sof)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit next_bit();
        seed = {seed[6:0], seed[7] ^ seed[5] ^ seed[4] ^ seed[3]};
        return seed[0];
    endfunction

    task automatic tick(input int l, input bit we, input bit ws, input bit wb,
                        input bit re, input bit rs, input bit ak);
        wr_en[l] = we; wr_sof[l] = ws; wr_bit[l] = wb;
        rd_en[l] = re; rd_sof[l] = rs; slip_ack[l] = ak;
        #1 txs = line_tx_sof;
        @(posedge clk);
        @(negedge clk);
        wr_en = '0; wr_sof = '0; wr_bit = '0;
        rd_en = '0; rd_sof = '0; slip_ack = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        q.delete();
        for (int i = 0; i < HALF; i++) q.push_back(1'b1);
        for (int l = 0; l < 2; l++) begin
            chk("R1 slip", slip[l], 0);
            chk("R1 warn", warn[l], 0);
            chk("R1 rd_bit", rd_bit[l], 1);
        end
    endtask

    task automatic prime(input int l);
        for (int i = 0; i < FB; i++) begin
            bit b = next_bit();
            tick(l, 1, i == 0, b, 1, 0, 0);
            chk("R2 idle ones", rd_bit[l], 1);
            void'(q.pop_front());
            q.push_back(b);
            if (l == 0) chk("R11 tx mark", txs, (i == 2) ? 1 : 0);
        end
    endtask

    task automatic lock(input int l, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            bit b = next_bit();
            bit e;
            tick(l, 1, 0, b, 1, 0, 0);
            e = q.pop_front();
            q.push_back(b);
            chk(req, rd_bit[l], e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        for (int l = 0; l < 2; l++) begin
            for (int we = 0; we < 2; we++) begin
                for (int d = -HALF; d <= HALF; d++) begin
                    int  ad = (d < 0) ? -d : d;
                    bit  es = ad > SD;
                    bit  ew = (we == 1) && (ad > WD) && !es;
                    warn_en = we[0];
                    do_reset();
                    prime(l);
                    lock(l, HALF, "R3 order");
                    for (int k = 0; k < ad; k++) begin
                        if (d > 0) begin
                            bit b = next_bit();
                            tick(l, 1, 0, b, 0, 0, 0);
                            q.push_back(b);
                        end else begin
                            bit e;
                            tick(l, 0, 0, 0, 1, 0, 0);
                            e = q.pop_front();
                            chk("R3 drain", rd_bit[l], e);
                        end
                    end
                    chk("R4 no strobe slip", slip[l], 0);
                    chk("R4 no strobe warn", warn[l], 0);
                    tick(l, 0, 0, 0, 0, 1, 0);
                    chk("R5 slip", slip[l], es);
                    chk("R8 warn", warn[l], ew);
                    chk("R12 other slip", slip[1-l], 0);
                    chk("R12 other warn", warn[1-l], 0);
                    if (es) begin
                        q.delete();
                        for (int k = 0; k < HALF; k++) begin
                            bit b = next_bit();
                            tick(l, 1, 0, b, 1, 0, 0);
                            q.push_back(b);
                        end
                        lock(l, HALF, "R6 recentre");
                        tick(l, 0, 0, 0, 0, 1, 0);
                        chk("R7 sticky", slip[l], 1);
                        tick(l, 0, 0, 0, 0, 0, 1);
                        chk("R7 ack", slip[l], 0);
                    end else begin
                        lock(l, HALF, "R3 after measure");
                        if (ew) begin
                            tick(l, 0, 0, 0, 0, 1, 0);
                            chk("R9 warn sticky", warn[l], 1);
                            tick(l, 0, 0, 0, 0, 0, 1);
                            chk("R9 warn ack", warn[l], 0);
                        end
                    end
                end
            end
        end

        // measurement coinciding with acknowledge
        warn_en = 1'b0;
        do_reset();
        prime(0);
        for (int k = 0; k < SD + 1; k++) tick(0, 1, 0, 1, 0, 0, 0);
        tick(0, 0, 0, 0, 0, 1, 1);
        chk("R10 measure wins", slip[0], 1);

        // escalation from warning to slip
        warn_en = 1'b1;
        do_reset();
        prime(1);
        for (int k = 0; k < SD; k++) tick(1, 1, 0, 0, 0, 0, 0);
        tick(1, 0, 0, 0, 0, 1, 0);
        chk("R9 warn first", warn[1], 1);
        tick(1, 1, 0, 0, 0, 0, 0);
        tick(1, 0, 0, 0, 0, 1, 0);
        chk("R9 slip raised", slip[1], 1);
        chk("R9 warn dropped", warn[1], 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule